// File: doc/BRIEF.md
# Type B Tag Response Serializer

This block turns a response held as bytes into the oversampled bit stream that a contactless Type B tag sends back to a reader. A start pulse latches the number of bytes to send. From then on the block emits one output sample per sample strobe, and every elementary time unit (ETU) lasts a fixed number of strobes. The frame has four parts in a fixed order: a run of ones so the reader can lock its phase reference, a start-of-frame delimiter, the framed characters, and an end-of-frame delimiter. The subcarrier modulator downstream consumes the stream.

Bytes are fetched over a valid/ready handshake. The payload already contains its CRC. The block asks for a byte only in the last ETU before the character that byte fills: the final high ETU of the start delimiter for the first byte, and the stop bit of the previous character for every later byte. Characters therefore follow each other with no gap. If the source offers nothing during that window, the frame is cut short and the end delimiter follows at once. A one-cycle done pulse closes every frame.

Top module: `tagb_resp_serializer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, tx_bit is 1, and busy, done and byte_ready are 0.
- R2: Every ETU lasts exactly SAMPLES_PER_ETU (default 4) sample strobes, and all samples of one ETU carry the same value.
- R3: A frame opens with PREAMBLE_ETU (default 20) ETUs of logic 1.
- R4: The start delimiter is DELIM_ZERO_ETU (default 10) ETUs of 0 followed by DELIM_ONE_ETU (default 2) ETUs of 1.
- R5: Each byte goes out as a 10-ETU character: a 0 start bit, data bit 0 first through data bit 7, then a 1 stop bit.
- R6: The start bit of a character follows the stop bit of the previous one directly, with no extra ETU between them.
- R7: The end delimiter is 10 ETUs of 0 followed by 2 ETUs of 1. With default parameters a frame of n characters lasts 4*(44+10n) strobes.
- R8: byte_ready is high only during the fetch window, only while bytes of the latched length remain, and drops in the cycle after a byte is accepted. The window is the last ETU of the start delimiter for byte 0 and the stop-bit ETU of byte k-1 for byte k.
- R9: A length of 0 produces the preamble, the start delimiter and the end delimiter with no characters.
- R10: done goes high for exactly one cycle, in the cycle after the strobe that takes the last sample of the end delimiter, and busy falls in that same cycle.
- R11: tx_bit changes only in a cycle that follows an accepted sample strobe.
- R12: If no byte is accepted by the end of a fetch window, the end delimiter starts in place of the next character.
- R13: A start pulse while a frame is in progress is ignored. The frame keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| frame_len | input | LEN_W | Number of payload bytes, latched on start |
| sample_en | input | 1 | Sample strobe; tx_bit is consumed in a cycle where this is high |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | byte_data is valid |
| byte_ready | output | 1 | The serializer takes byte_data when byte_valid is also high |
| tx_bit | output | 1 | Current output sample |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions check on every cycle that the idle line stays high, that tx_bit holds steady between strobes, and that byte_ready appears only inside a frame and drops once a byte is taken. They also check that done is a single cycle that coincides with the fall of busy after a strobe. Only the bench scenarios can show the actual shape of the frame: each sample is compared with a bit sequence computed from the length and the payload, and each fetch window is placed at its expected strobe count. The bench covers lengths from 0 to 6 at several strobe spacings, a 255-byte frame that carries nearly every byte value, withheld bytes that truncate the frame, and a start pulse issued in the middle of a frame.

// File: rtl/tagb_ser_pkg.sv
package tagb_ser_pkg;

    // Bits in one character: start, eight data bits, stop.
    localparam int CHAR_ETU = 10;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF_LO,
        PH_SOF_HI,
        PH_CHAR,
        PH_EOF_LO,
        PH_EOF_HI
    } phase_e;

endpackage

// File: rtl/tagb_etu_timer.sv
// Counts sample strobes inside one ETU and flags the strobe that closes it.
module tagb_etu_timer #(
    parameter int SAMPLES_PER_ETU = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic etu_last
);
    localparam int CNT_W = (SAMPLES_PER_ETU > 1) ? $clog2(SAMPLES_PER_ETU) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        etu_last = tick && (int'(s_q.cnt) == SAMPLES_PER_ETU - 1);
        if (clear) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (etu_last) s_d.cnt = '0;
            else          s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tagb_char_shifter.sv
// Holds a fetched byte and shifts out the framed character, lowest bit first.
module tagb_char_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic [7:0] cap_data,
    input  logic       load_en,
    input  logic       shift_en,
    output logic       char_bit
);
    import tagb_ser_pkg::*;

    typedef struct packed {
        logic [7:0]          hold;
        logic [CHAR_ETU-1:0] sreg;
    } shf_t;

    shf_t       s_d, s_q;
    logic [7:0] src;

    always_comb begin
        s_d = s_q;
        src = cap_en ? cap_data : s_q.hold;
        if (cap_en) s_d.hold = cap_data;
        if (load_en) begin
            s_d.sreg = {1'b1, src, 1'b0};
        end else if (shift_en) begin
            s_d.sreg = {1'b1, s_q.sreg[CHAR_ETU-1:1]};
        end
        char_bit = s_q.sreg[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hold <= '0;
            s_q.sreg <= '1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tagb_frame_seq.sv
// Walks the frame phases, counts ETUs, runs the byte fetch handshake.
module tagb_frame_seq #(
    parameter int PREAMBLE_ETU   = 20,
    parameter int DELIM_ZERO_ETU = 10,
    parameter int DELIM_ONE_ETU  = 2,
    parameter int LEN_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             etu_last,
    input  logic             byte_valid,
    input  logic             char_bit,
    output logic             byte_ready,
    output logic             cap_en,
    output logic             load_en,
    output logic             shift_en,
    output logic             timer_clear,
    output logic             tx_bit,
    output logic             busy,
    output logic             done
);
    import tagb_ser_pkg::*;

    localparam int MAX_A  = (PREAMBLE_ETU > DELIM_ZERO_ETU) ? PREAMBLE_ETU : DELIM_ZERO_ETU;
    localparam int MAX_B  = (DELIM_ONE_ETU > CHAR_ETU) ? DELIM_ONE_ETU : CHAR_ETU;
    localparam int MAX_P  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int ETU_W  = $clog2(MAX_P + 1);

    typedef struct packed {
        phase_e           phase;
        logic [ETU_W-1:0] etu_cnt;
        logic [LEN_W-1:0] left;
        logic             have;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    int   plen;
    logic last_etu;
    logic window;
    logic accept;

    function automatic int phase_len(input phase_e ph);
        case (ph)
            PH_PRE:               return PREAMBLE_ETU;
            PH_SOF_LO, PH_EOF_LO: return DELIM_ZERO_ETU;
            PH_SOF_HI, PH_EOF_HI: return DELIM_ONE_ETU;
            PH_CHAR:              return CHAR_ETU;
            default:              return 1;
        endcase
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        load_en     = 1'b0;
        shift_en    = 1'b0;
        timer_clear = 1'b0;

        plen       = phase_len(s_q.phase);
        last_etu   = (int'(s_q.etu_cnt) == plen - 1);
        window     = ((s_q.phase == PH_SOF_HI) || (s_q.phase == PH_CHAR))
                     && last_etu && (s_q.left != '0);
        byte_ready = window && !s_q.have;
        accept     = byte_ready && byte_valid;
        cap_en     = accept;

        if (accept) begin
            s_d.left = s_q.left - LEN_W'(1);
            s_d.have = 1'b1;
        end

        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.phase   = PH_PRE;
                s_d.etu_cnt = '0;
                s_d.left    = frame_len;
                s_d.have    = 1'b0;
                timer_clear = 1'b1;
            end
        end else if (etu_last) begin
            if (last_etu) begin
                s_d.etu_cnt = '0;
                case (s_q.phase)
                    PH_PRE:    s_d.phase = PH_SOF_LO;
                    PH_SOF_LO: s_d.phase = PH_SOF_HI;
                    PH_SOF_HI, PH_CHAR: begin
                        if (s_q.have || accept) begin
                            s_d.phase = PH_CHAR;
                            s_d.have  = 1'b0;
                            load_en   = 1'b1;
                        end else begin
                            s_d.phase = PH_EOF_LO;
                        end
                    end
                    PH_EOF_LO: s_d.phase = PH_EOF_HI;
                    PH_EOF_HI: begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end
                    default:   s_d.phase = PH_IDLE;
                endcase
            end else begin
                s_d.etu_cnt = s_q.etu_cnt + ETU_W'(1);
                shift_en    = (s_q.phase == PH_CHAR);
            end
        end

        case (s_q.phase)
            PH_SOF_LO, PH_EOF_LO: tx_bit = 1'b0;
            PH_CHAR:              tx_bit = char_bit;
            default:              tx_bit = 1'b1;
        endcase
        busy = (s_q.phase != PH_IDLE);
        done = s_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase   <= PH_IDLE;
            s_q.etu_cnt <= '0;
            s_q.left    <= '0;
            s_q.have    <= 1'b0;
            s_q.done    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tagb_resp_serializer.sv
module tagb_resp_serializer #(
    parameter int SAMPLES_PER_ETU = 4,
    parameter int PREAMBLE_ETU    = 20,
    parameter int DELIM_ZERO_ETU  = 10,
    parameter int DELIM_ONE_ETU   = 2,
    parameter int LEN_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             sample_en,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    output logic             byte_ready,
    output logic             tx_bit,
    output logic             busy,
    output logic             done
);
    logic etu_last;
    logic timer_clear;
    logic cap_en;
    logic load_en;
    logic shift_en;
    logic char_bit;
    logic tick;

    assign tick = sample_en && busy;

    tagb_etu_timer #(
        .SAMPLES_PER_ETU(SAMPLES_PER_ETU)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .tick     (tick),
        .etu_last (etu_last)
    );

    tagb_char_shifter shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_data (byte_data),
        .load_en  (load_en),
        .shift_en (shift_en),
        .char_bit (char_bit)
    );

    tagb_frame_seq #(
        .PREAMBLE_ETU   (PREAMBLE_ETU),
        .DELIM_ZERO_ETU (DELIM_ZERO_ETU),
        .DELIM_ONE_ETU  (DELIM_ONE_ETU),
        .LEN_W          (LEN_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .frame_len   (frame_len),
        .etu_last    (etu_last),
        .byte_valid  (byte_valid),
        .char_bit    (char_bit),
        .byte_ready  (byte_ready),
        .cap_en      (cap_en),
        .load_en     (load_en),
        .shift_en    (shift_en),
        .timer_clear (timer_clear),
        .tx_bit      (tx_bit),
        .busy        (busy),
        .done        (done)
    );
endmodule

// File: rtl/tagb_ser_checker.sv
module tagb_ser_checker (
    input logic clk,
    input logic rst_n,
    input logic sample_en,
    input logic byte_valid,
    input logic byte_ready,
    input logic tx_bit,
    input logic busy,
    input logic done
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_bit); // R1

    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> busy); // R8

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && byte_valid) |=> !byte_ready); // R8

    AST_LINE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(tx_bit)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $past(sample_en))); // R10
endmodule

bind tagb_resp_serializer tagb_ser_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .tx_bit     (tx_bit),
    .busy       (busy),
    .done       (done)
);

// File: tb/tagb_resp_serializer_tb.sv
module tagb_resp_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] frame_len = '0;
    logic       sample_en = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic       tx_bit;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] pat [0:255];

    always #5 clk = ~clk;

    tagb_resp_serializer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_len  (frame_len),
        .sample_en  (sample_en),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .tx_bit     (tx_bit),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected sample: R3 preamble, R4 start delimiter, R5 characters, R7 end delimiter.
    function automatic bit exp_bit(input int idx, input int n);
        int e;
        int c;
        e = idx / 4;
        if (e < 20) return 1'b1;
        if (e < 30) return 1'b0;
        if (e < 32) return 1'b1;
        c = e - 32;
        if (c < 10 * n) begin
            int p;
            int b;
            p = c % 10;
            b = c / 10;
            if (p == 0) return 1'b0;
            if (p == 9) return 1'b1;
            return pat[b][p-1];
        end
        c = c - 10 * n;
        return (c >= 10);
    endfunction

    function automatic string region_tag(input int idx, input int n);
        int e;
        e = idx / 4;
        if (e < 20) return "R3";
        if (e < 32) return "R4";
        if (e < 32 + 10 * n) begin
            if (((e - 32) % 10 == 0) && (e > 32)) return "R6";
            return "R5";
        end
        return "R7";
    endfunction

    task automatic run_frame(input int n, input int spacing, input int stall_at, input bit restart);
        int  n_eff;
        int  total;
        int  strobes;
        int  nxt;
        int  tick;
        int  cyc;
        bit  prev_quiet;
        bit  prev_tx;
        bit  last_sample;
        bit  finished;
        n_eff = (stall_at >= 0) ? stall_at : n;
        total = 4 * (44 + 10 * n_eff);
        strobes = 0; nxt = 0; tick = 0; cyc = 0;
        prev_quiet = 1'b0; prev_tx = 1'b1; last_sample = 1'b1; finished = 1'b0;
        @(negedge clk);
        start = 1'b1; frame_len = 8'(n); sample_en = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        frame_len = 8'(n + 3);
        while (!finished) begin
            if (done) begin
                if (restart)     chk(strobes == total, "R13", strobes, total);
                else if (n == 0) chk(strobes == total, "R9", strobes, total);
                else             chk(strobes == total, "R7", strobes, total);
                chk(!busy, "R10", int'(busy), 0);
                finished = 1'b1;
            end else if (cyc > total * spacing + 200) begin
                chk(1'b0, "R10 frame never ended", cyc, total * spacing);
                finished = 1'b1;
            end else begin
                sample_en  = ((tick % spacing) == spacing - 1);
                tick++;
                start      = restart && (strobes == 100);
                byte_valid = 1'b0;
                if (byte_ready) begin
                    if (nxt < n_eff) begin
                        chk(strobes == 4 * (31 + 10 * nxt), "R8", strobes, 4 * (31 + 10 * nxt));
                        byte_valid = 1'b1;
                        byte_data  = pat[nxt];
                        nxt++;
                    end else if ((nxt == stall_at) && (nxt < n)) begin
                        chk(strobes / 4 == 31 + 10 * nxt, "R12", strobes / 4, 31 + 10 * nxt);
                    end else begin
                        chk(1'b0, "R8 ready outside window", strobes, -1);
                    end
                end
                if (sample_en) begin
                    chk(tx_bit == exp_bit(strobes, n_eff), region_tag(strobes, n_eff),
                        int'(tx_bit), int'(exp_bit(strobes, n_eff)));
                    if (strobes % 4 != 0)
                        chk(tx_bit == last_sample, "R2", int'(tx_bit), int'(last_sample));
                    last_sample = tx_bit;
                    strobes++;
                end else if (prev_quiet) begin
                    chk(tx_bit == prev_tx, "R11", int'(tx_bit), int'(prev_tx));
                end
                prev_quiet = !sample_en;
                prev_tx    = tx_bit;
                cyc++;
                @(negedge clk);
            end
        end
        sample_en = 1'b0; start = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        chk(!done, "R10", int'(done), 0);
        chk(tx_bit, "R1", int'(tx_bit), 1);
        chk(!byte_ready, "R1", int'(byte_ready), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b1, "R1", int'(tx_bit), 1);
        chk(!busy, "R1", int'(busy), 0);
        chk(!done, "R1", int'(done), 0);
        chk(!byte_ready, "R1", int'(byte_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_bit == 1'b1 && !busy, "R1", int'(tx_bit), 1);

        // Sweep of short lengths and strobe spacings (length 0 covers R9).
        for (int n = 0; n <= 6; n++) begin
            for (int sp = 1; sp <= 3; sp++) begin
                for (int k = 0; k < 256; k++) pat[k] = 8'((k * 37 + n * 11 + sp * 5) & 255);
                run_frame(n, sp, -1, 1'b0);
            end
        end

        // Long frame with nearly every byte value (R5, R6).
        for (int k = 0; k < 256; k++) pat[k] = 8'(k) ^ 8'h5A;
        run_frame(255, 1, -1, 1'b0);

        // Withheld bytes truncate the frame (R12).
        for (int k = 0; k < 256; k++) pat[k] = 8'(k * 91 + 3);
        run_frame(4, 1, 0, 1'b0);
        run_frame(4, 2, 2, 1'b0);

        // Start pulse during a frame (R13).
        run_frame(3, 2, -1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule